// File: doc/BRIEF.md
# Processor-Bus Peripheral Register Bank

This block places five registers of different behaviour behind a single address decoder on an 8-bit processor bus with a 16-bit address. A host cycle reaches the bank when the upper address bits match the bank's base address and the active-low request strobe is low. The low address bits then pick one register. Depending on its kind, that register is read, written, or both.

Software sees five registers in a fixed order:

- A status input that hardware drives and software can only read.
- A plain read/write configuration byte.
- A byte whose bits software sets and hardware clears.
- A read-only byte that emits a one-cycle pulse each time it is read.
- A read/write byte that emits a one-cycle pulse each time it is written.

Read data leaves through a priority multiplexer. A data-output-enable flag tells the surrounding bus fabric when the bank is driving. The request strobe is generic: it may be wired to either an I/O request or a memory request.

Top module: `periph_regbank`

## Requirements
- R1: Synchronous active-high reset sets the configuration byte to CFG_RST (default 8'h12), the set/clear byte to SSET_RST (default 8'h00) and the write-strobe byte to WSTB_RST (default 8'h00). Both strobe outputs go low.
- R2: The bank is selected only when addr[15:3] equals BASE_ADDR[15:3] (default base 16'h0040) and req_n is low. Any other access changes no register and leaves doe low.
- R3: Offsets in addr[2:0] are 0 status, 1 configuration, 2 set/clear, 3 read-strobe, 4 write-strobe. A selected cycle with rd_n low drives that register's value on rd_data and raises doe combinationally in the same cycle.
- R4: A selected read at offsets 5, 6 or 7 leaves doe low and returns zero.
- R5: The configuration byte loads wr_data at a clock edge where it is selected with wr_n low, and holds its value otherwise.
- R6: At each edge the set/clear byte becomes (current OR wr_data when write-selected) AND NOT sset_clr. A clear bit wins over a set of the same bit in the same cycle.
- R7: rstb_pulse is high for exactly the one cycle after an edge at which offset 3 was read-selected, and low otherwise.
- R8: The write-strobe byte stores wr_data like the configuration byte, and wstb_pulse is high for exactly the one cycle after each such write.
- R9: Writes to offsets 0 and 3 have no effect on any register.
- R10: Whenever doe is low, rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Bus address |
| wr_data | input | 8 | Write data from host |
| rd_data | output | 8 | Read data to host |
| doe | output | 1 | High while the bank drives read data |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| req_n | input | 1 | Active-low bus request (I/O or memory) |
| stat_in | input | 8 | Hardware status value, offset 0 |
| cfg_q | output | 8 | Configuration byte, offset 1 |
| sset_q | output | 8 | Set/clear byte, offset 2 |
| sset_clr | input | 8 | Per-bit hardware clear of the set/clear byte |
| rstb_in | input | 8 | Hardware value read at offset 3 |
| rstb_pulse | output | 1 | One-cycle pulse after a read of offset 3 |
| wstb_q | output | 8 | Write-strobe byte, offset 4 |
| wstb_pulse | output | 1 | One-cycle pulse after a write of offset 4 |

## Verification
A decoder that wrongly matches a foreign address or ignores req_n corrupts a stored byte. That corruption only shows at the next read of the byte or on its output port, so the bench re-reads every writable register after each rejected access. A stuck or stretched strobe shows one cycle after the triggering access, which is where the bench samples both pulses. A set/clear byte that lets a set beat a same-cycle clear shows on sset_q at the very next edge.

// File: rtl/regbank_pkg.sv
`timescale 1ns/1ps
package regbank_pkg;
  localparam int NUM_REGS = 5;
  localparam int LOCAL_W  = $clog2(NUM_REGS);

  localparam int OFF_STAT = 0;
  localparam int OFF_CFG  = 1;
  localparam int OFF_SSET = 2;
  localparam int OFF_RSTB = 3;
  localparam int OFF_WSTB = 4;

  // which offsets accept a write
  localparam logic [NUM_REGS-1:0] WRITABLE_MASK = 5'b10110;

  typedef enum logic [1:0] {
    CELL_CFG  = 2'd0,
    CELL_SSET = 2'd1,
    CELL_RSTB = 2'd2,
    CELL_WSTB = 2'd3
  } cell_kind_e;
endpackage

// File: rtl/regbank_decode.sv
`timescale 1ns/1ps
module regbank_decode #(
  parameter int ADDR_W = 16,
  parameter int NREG = 5,
  parameter int LW = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040,
  parameter logic [NREG-1:0] WR_MASK = 5'b10110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              req_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic [NREG-1:0]   rd_sel,
  output logic [NREG-1:0]   wr_sel
);
  logic blk_hit;
  assign blk_hit = (addr[ADDR_W-1:LW] == BASE_ADDR[ADDR_W-1:LW]) && !req_n;

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    logic off_hit;
    assign off_hit   = blk_hit && (addr[LW-1:0] == LW'(i));
    assign rd_sel[i] = off_hit && !rd_n;
    if (WR_MASK[i]) begin : g_wr
      assign wr_sel[i] = off_hit && !wr_n;
    end else begin : g_ro
      assign wr_sel[i] = 1'b0;
    end
  end

  // R2: foreign address or idle request never selects a register
  p_foreign_nosel_r2: assert property (@(posedge clk) disable iff (rst)
    (req_n || addr[ADDR_W-1:LW] != BASE_ADDR[ADDR_W-1:LW]) |-> (rd_sel == '0 && wr_sel == '0));
  // R9: read-only offsets never see a write select
  p_ro_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_sel & ~WR_MASK) == '0);
  // R3: at most one register read-selected
  p_rdsel_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_sel));
endmodule

// File: rtl/regbank_rdmux.sv
`timescale 1ns/1ps
module regbank_rdmux #(
  parameter int DATA_W = 8,
  parameter int NREG = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NREG-1:0]              rd_sel,
  input  logic [NREG-1:0][DATA_W-1:0]  rd_src,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         doe
);
  always_comb begin
    rd_data = '0;
    // descending walk: lowest offset has priority
    for (int i = NREG - 1; i >= 0; i--) begin
      if (rd_sel[i]) rd_data = rd_src[i];
    end
  end

  assign doe = |rd_sel;

  // R10: bank drives zero whenever it is not enabled
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !doe |-> rd_data == '0);
endmodule

// File: rtl/regbank_cell.sv
`timescale 1ns/1ps
module regbank_cell
  import regbank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter cell_kind_e KIND = CELL_CFG,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sel,
  input  logic              rd_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] clr,
  output logic [DATA_W-1:0] q,
  output logic              pulse
);
  if (KIND == CELL_CFG || KIND == CELL_WSTB) begin : g_store
    always_ff @(posedge clk) begin
      if (rst)         q <= RST_VAL;
      else if (wr_sel) q <= wr_data;
    end
    // R5 / R8: stored byte holds unless written
    p_hold_unwritten_r5: assert property (@(posedge clk) disable iff (rst)
      !wr_sel |=> $stable(q));
    p_load_written_r8: assert property (@(posedge clk) disable iff (rst)
      wr_sel |=> q == $past(wr_data));
  end else if (KIND == CELL_SSET) begin : g_sset
    always_ff @(posedge clk) begin
      if (rst) q <= RST_VAL;
      else     q <= ((wr_data & {DATA_W{wr_sel}}) | q) & ~clr;
    end
    // R6: a cleared bit is zero after the edge, even if set in the same cycle
    p_clear_wins_r6: assert property (@(posedge clk) disable iff (rst)
      (clr != '0) |=> (q & $past(clr)) == '0);
  end else begin : g_noq
    assign q = '0;
  end

  if (KIND == CELL_WSTB) begin : g_wpulse
    always_ff @(posedge clk) begin
      if (rst) pulse <= 1'b0;
      else     pulse <= wr_sel;
    end
    p_wpulse_one_r8: assert property (@(posedge clk) disable iff (rst)
      pulse |=> !pulse || $past(wr_sel));
  end else if (KIND == CELL_RSTB) begin : g_rpulse
    always_ff @(posedge clk) begin
      if (rst) pulse <= 1'b0;
      else     pulse <= rd_sel;
    end
    p_rpulse_after_read_r7: assert property (@(posedge clk) disable iff (rst)
      rd_sel |=> pulse);
    p_rpulse_idle_r7: assert property (@(posedge clk) disable iff (rst)
      !rd_sel |=> !pulse);
  end else begin : g_nopulse
    assign pulse = 1'b0;
  end

  logic unused_inputs;
  assign unused_inputs = ^{rd_sel, clr, wr_data, wr_sel};
endmodule

// File: rtl/periph_regbank.sv
`timescale 1ns/1ps
module periph_regbank
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040,
  parameter logic [DATA_W-1:0] CFG_RST  = 8'h12,
  parameter logic [DATA_W-1:0] SSET_RST = 8'h00,
  parameter logic [DATA_W-1:0] WSTB_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              doe,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              req_n,
  input  logic [DATA_W-1:0] stat_in,
  output logic [DATA_W-1:0] cfg_q,
  output logic [DATA_W-1:0] sset_q,
  input  logic [DATA_W-1:0] sset_clr,
  input  logic [DATA_W-1:0] rstb_in,
  output logic              rstb_pulse,
  output logic [DATA_W-1:0] wstb_q,
  output logic              wstb_pulse
);
  localparam int NREG = NUM_REGS;
  localparam int LW   = LOCAL_W;

  logic [NREG-1:0]             rd_sel, wr_sel;
  logic [NREG-1:0][DATA_W-1:0] rd_src;
  logic                        cfg_pulse_unused, sset_pulse_unused;
  logic [DATA_W-1:0]           rstb_q_unused;

  regbank_decode #(
    .ADDR_W(ADDR_W), .NREG(NREG), .LW(LW),
    .BASE_ADDR(BASE_ADDR), .WR_MASK(WRITABLE_MASK)
  ) u_decode (
    .clk(clk), .rst(rst), .addr(addr), .req_n(req_n),
    .rd_n(rd_n), .wr_n(wr_n), .rd_sel(rd_sel), .wr_sel(wr_sel)
  );

  regbank_cell #(.DATA_W(DATA_W), .KIND(CELL_CFG), .RST_VAL(CFG_RST)) u_cfg (
    .clk(clk), .rst(rst), .wr_sel(wr_sel[OFF_CFG]), .rd_sel(rd_sel[OFF_CFG]),
    .wr_data(wr_data), .clr('0), .q(cfg_q), .pulse(cfg_pulse_unused)
  );

  regbank_cell #(.DATA_W(DATA_W), .KIND(CELL_SSET), .RST_VAL(SSET_RST)) u_sset (
    .clk(clk), .rst(rst), .wr_sel(wr_sel[OFF_SSET]), .rd_sel(rd_sel[OFF_SSET]),
    .wr_data(wr_data), .clr(sset_clr), .q(sset_q), .pulse(sset_pulse_unused)
  );

  regbank_cell #(.DATA_W(DATA_W), .KIND(CELL_RSTB), .RST_VAL('0)) u_rstb (
    .clk(clk), .rst(rst), .wr_sel(wr_sel[OFF_RSTB]), .rd_sel(rd_sel[OFF_RSTB]),
    .wr_data(wr_data), .clr('0), .q(rstb_q_unused), .pulse(rstb_pulse)
  );

  regbank_cell #(.DATA_W(DATA_W), .KIND(CELL_WSTB), .RST_VAL(WSTB_RST)) u_wstb (
    .clk(clk), .rst(rst), .wr_sel(wr_sel[OFF_WSTB]), .rd_sel(rd_sel[OFF_WSTB]),
    .wr_data(wr_data), .clr('0), .q(wstb_q), .pulse(wstb_pulse)
  );

  assign rd_src[OFF_STAT] = stat_in;
  assign rd_src[OFF_CFG]  = cfg_q;
  assign rd_src[OFF_SSET] = sset_q;
  assign rd_src[OFF_RSTB] = rstb_in;
  assign rd_src[OFF_WSTB] = wstb_q;

  regbank_rdmux #(.DATA_W(DATA_W), .NREG(NREG)) u_rdmux (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_src(rd_src),
    .rd_data(rd_data), .doe(doe)
  );

  // R2: the bank drives only during a requested read
  p_doe_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
    doe |-> (!req_n && !rd_n));
  // R4: unused offsets never enable the bus
  p_gap_offsets_r4: assert property (@(posedge clk) disable iff (rst)
    (addr[LW-1:0] >= LW'(NREG)) |-> !doe);
endmodule

// File: tb/periph_regbank_tb.sv
`timescale 1ns/1ps
module periph_regbank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        doe;
  logic        rd_n = 1'b1, wr_n = 1'b1, req_n = 1'b1;
  logic [7:0]  stat_in = 8'hA5, rstb_in = 8'h3C, sset_clr = '0;
  logic [7:0]  cfg_q, sset_q, wstb_q;
  logic        rstb_pulse, wstb_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] cap_rd;
  logic       cap_doe;

  always #2 clk = ~clk;

  periph_regbank u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .doe(doe), .rd_n(rd_n), .wr_n(wr_n), .req_n(req_n), .stat_in(stat_in),
    .cfg_q(cfg_q), .sset_q(sset_q), .sset_clr(sset_clr), .rstb_in(rstb_in),
    .rstb_pulse(rstb_pulse), .wstb_q(wstb_q), .wstb_pulse(wstb_pulse)
  );

  // {req_idle, is_write, addr, data, exp_rd, exp_doe}
  localparam int NV = 26;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h0040, 8'h00, 8'hA5, 1'b1},
    {1'b0, 1'b0, 16'h0041, 8'h00, 8'h12, 1'b1},
    {1'b0, 1'b1, 16'h0041, 8'h5A, 8'h00, 1'b0},
    {1'b0, 1'b0, 16'h0041, 8'h00, 8'h5A, 1'b1},
    {1'b0, 1'b1, 16'h0042, 8'h81, 8'h00, 1'b0},
    {1'b0, 1'b0, 16'h0042, 8'h00, 8'h81, 1'b1},
    {1'b0, 1'b1, 16'h0042, 8'h06, 8'h00, 1'b0},
    {1'b0, 1'b0, 16'h0042, 8'h00, 8'h87, 1'b1},
    {1'b0, 1'b0, 16'h0043, 8'h00, 8'h3C, 1'b1},
    {1'b0, 1'b1, 16'h0044, 8'hC3, 8'h00, 1'b0},
    {1'b0, 1'b0, 16'h0044, 8'h00, 8'hC3, 1'b1},
    {1'b0, 1'b0, 16'h0045, 8'h00, 8'h00, 1'b0},
    {1'b0, 1'b0, 16'h0047, 8'h00, 8'h00, 1'b0},
    {1'b0, 1'b1, 16'h0040, 8'hFF, 8'h00, 1'b0},
    {1'b0, 1'b1, 16'h0043, 8'hFF, 8'h00, 1'b0},
    {1'b0, 1'b0, 16'h0040, 8'h00, 8'hA5, 1'b1},
    {1'b0, 1'b0, 16'h0043, 8'h00, 8'h3C, 1'b1},
    {1'b0, 1'b1, 16'h0049, 8'h77, 8'h00, 1'b0},
    {1'b0, 1'b1, 16'h0001, 8'h77, 8'h00, 1'b0},
    {1'b1, 1'b1, 16'h0041, 8'h99, 8'h00, 1'b0},
    {1'b0, 1'b0, 16'h0041, 8'h00, 8'h5A, 1'b1},
    {1'b1, 1'b0, 16'h0041, 8'h00, 8'h00, 1'b0},
    {1'b0, 1'b0, 16'h0049, 8'h00, 8'h00, 1'b0},
    {1'b0, 1'b0, 16'h00C1, 8'h00, 8'h00, 1'b0},
    {1'b0, 1'b0, 16'h0042, 8'h00, 8'h87, 1'b1},
    {1'b0, 1'b0, 16'h0044, 8'h00, 8'hC3, 1'b1}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic idle, input logic wr,
                           input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d;
    req_n = idle; rd_n = wr; wr_n = !wr;
    #1;
    cap_rd = rd_data; cap_doe = doe;
    @(negedge clk);
    req_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 cfg_q", cfg_q, 8'h12);
    chk("R1 sset_q", sset_q, 8'h00);
    chk("R1 wstb_q", wstb_q, 8'h00);
    chk("R1 pulses", {6'b0, rstb_pulse, wstb_pulse}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      bus_cycle(VEC[i][34], VEC[i][33], VEC[i][32:17], VEC[i][16:9]);
      if (!VEC[i][33]) begin
        if (VEC[i][0]) chk($sformatf("R3 read %h", VEC[i][32:17]), cap_rd, VEC[i][8:1]);
        else           chk($sformatf("R2 R4 R10 rd %h", VEC[i][32:17]), cap_rd, 8'h00);
        chk($sformatf("R2 R3 R4 doe %h", VEC[i][32:17]), {7'b0, cap_doe}, {7'b0, VEC[i][0]});
      end else begin
        chk($sformatf("R9 doe on write %h", VEC[i][32:17]), {7'b0, cap_doe}, 8'h00);
      end
    end
    chk("R5 cfg_q port", cfg_q, 8'h5A);
    chk("R2 R9 sset_q untouched", sset_q, 8'h87);

    // R6: clear beats a same-cycle set of the same bit
    sset_clr = 8'h01;
    bus_cycle(1'b0, 1'b1, 16'h0042, 8'h01);
    sset_clr = 8'h00;
    chk("R6 clear wins", sset_q, 8'h86);
    // R6: hardware clear without write
    @(negedge clk); sset_clr = 8'h80;
    @(negedge clk); sset_clr = 8'h00; #1;
    chk("R6 hw clear", sset_q, 8'h06);

    // R7: read strobe pulse
    bus_cycle(1'b0, 1'b0, 16'h0043, 8'h00);
    chk("R7 pulse after read", {7'b0, rstb_pulse}, 8'h01);
    @(negedge clk); #1;
    chk("R7 pulse one cycle", {7'b0, rstb_pulse}, 8'h00);
    bus_cycle(1'b0, 1'b0, 16'h0042, 8'h00);
    chk("R7 no pulse other read", {7'b0, rstb_pulse}, 8'h00);

    // R8: write strobe
    bus_cycle(1'b0, 1'b1, 16'h0044, 8'h5E);
    chk("R8 pulse after write", {7'b0, wstb_pulse}, 8'h01);
    chk("R8 stored value", wstb_q, 8'h5E);
    @(negedge clk); #1;
    chk("R8 pulse one cycle", {7'b0, wstb_pulse}, 8'h00);
    bus_cycle(1'b0, 1'b1, 16'h0041, 8'h33);
    chk("R8 no pulse cfg write", {7'b0, wstb_pulse}, 8'h00);
    chk("R5 cfg rewrite", cfg_q, 8'h33);

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    chk("R1 cfg after rerst", cfg_q, 8'h12);
    chk("R1 sset after rerst", sset_q, 8'h00);
    chk("R1 wstb after rerst", wstb_q, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule